// File: doc/BRIEF.md
# Banked Extended Scratch-Memory Window

This block sits on a small synchronous byte bus and exposes a large internal scratch memory through a handful of byte registers. The scratch memory is too big to map directly into the 128-byte register space. The host therefore loads a two-byte pointer and then moves bytes one at a time through a single data-port register.

A bank-select bit in a control register chooses what the upper half of the register space shows. With the bit clear, that half holds general-purpose bytes, alongside the general bytes that are always visible in the lower half. With the bit set, the upper half becomes the extended page, which holds the pointer registers, the data port and an extended control register. The extended control register carries a burst enable. While burst is on, the pointer advances by one after every data-port read or write, so a block of bytes can be streamed without reloading the pointer.

Top module: `xram_port`

## Requirements
- R1: After reset the bank-select bit is 0, burst mode is off, the pointer is 0 and `bus_rdata` reads 0x00.
- R2: Offset 0x0A is visible in both banks. Its bit 4 is the bank select. A read of 0x0A returns only that bit, in position 4, with all other bits 0.
- R3: Offsets 0x0E–0x3F are general bytes in both banks. With bank select 0, offsets 0x40–0x7F are further general bytes. Those bytes keep their contents while bank 1 is selected and its extended page is accessed, and bank-0 writes never move the pointer.
- R4: With bank select 1, offset 0x50 loads and reads the pointer's low byte, and 0x51 loads and reads its high byte. High-byte bits above log2(EXT_DEPTH)−8 are discarded on write and read back as 0.
- R5: With bank select 1, a write to offset 0x53 stores the byte at the pointer location. A read of 0x53 returns the byte at the pointer location.
- R6: With burst off, data-port accesses leave the pointer unchanged.
- R7: Offset 0x4A (bank 1) bit 5 enables burst; a read of 0x4A returns only that bit. With burst on, every data-port read or write advances the pointer by one after the access, so a read returns the byte at the pointer value from before the increment.
- R8: With burst on, the pointer wraps from EXT_DEPTH−1 to 0.
- R9: A read strobe in cycle t presents its data on `bus_rdata` after the next rising edge. The value holds until the next read strobe.
- R10: Unmapped offsets (0x00–0x09, 0x0B–0x0D, and the rest of the bank-1 page) read as 0x00. Writes to them change no mapped location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read byte, valid after the edge that samples the strobe |

## Verification
The hardest behaviour to reach from the ports is the pointer wrapping at the top of the scratch memory while burst is active. The stimulus loads the pointer with the last location, writes one byte and then a second one. It then reloads the last location and reads twice, which proves that the second byte went to location 0. A related case is the aliasing of offsets 0x40–0x7F between the two banks. The bench writes general bytes at offsets that coincide with the pointer and data-port offsets in bank 0. It then switches banks and checks that the pointer did not move and that the general bytes survived.

// File: rtl/xram_pkg.sv
package xram_pkg;
  typedef enum logic [2:0] {
    TGT_NONE, TGT_CTRL, TGT_GEN, TGT_XCTRL, TGT_PLO, TGT_PHI, TGT_DATA
  } tgt_e;

  typedef enum logic [1:0] {SRC_REG, SRC_GEN, SRC_EXT} src_e;

  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 7'h0A;
  localparam logic [ADDR_W-1:0] OFS_GEN_LO = 7'h0E;
  localparam logic [ADDR_W-1:0] OFS_PAGE   = 7'h40;
  localparam logic [ADDR_W-1:0] OFS_XCTRL  = 7'h4A;
  localparam logic [ADDR_W-1:0] OFS_PLO    = 7'h50;
  localparam logic [ADDR_W-1:0] OFS_PHI    = 7'h51;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 7'h53;
  localparam int BANK_BIT  = 4;
  localparam int BURST_BIT = 5;
endpackage

// File: rtl/xram_decode.sv
module xram_decode
  import xram_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank,
  output tgt_e              tgt
);
  always_comb begin
    tgt = TGT_NONE;
    if (addr == OFS_CTRL) begin
      tgt = TGT_CTRL;
    end else if (addr >= OFS_GEN_LO && addr < OFS_PAGE) begin
      tgt = TGT_GEN;
    end else if (addr >= OFS_PAGE) begin
      if (!bank) begin
        tgt = TGT_GEN;
      end else begin
        case (addr)
          OFS_XCTRL: tgt = TGT_XCTRL;
          OFS_PLO:   tgt = TGT_PLO;
          OFS_PHI:   tgt = TGT_PHI;
          OFS_DATA:  tgt = TGT_DATA;
          default:   tgt = TGT_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/xram_ptr.sv
module xram_ptr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [7:0]    wbyte,
  input  logic          step,
  input  logic          burst,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (ld_lo) begin
      ptr[7:0] <= wbyte;
    end else if (ld_hi) begin
      ptr <= AW'({wbyte, ptr[7:0]});
    end else if (step && burst) begin
      ptr <= ptr + 1'b1;
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ld_lo && !ld_hi && !(step && burst)) |=> $stable(ptr)); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && burst && !ld_lo && !ld_hi && ptr != '1) |=> (ptr == AW'($past(ptr) + 1'b1))); // R7
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && burst && !ld_lo && !ld_hi && ptr == '1) |=> (ptr == '0)); // R8
endmodule

// File: rtl/xram_mem.sv
module xram_mem #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/xram_port.sv
module xram_port
  import xram_pkg::*;
#(
  parameter int EXT_DEPTH = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [6:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata
);
  localparam int AW        = $clog2(EXT_DEPTH);
  localparam int GEN_DEPTH = 1 << ADDR_W;

  initial begin
    AST_DEPTH_SHAPE: assert ((1 << AW) == EXT_DEPTH && AW > 8 && AW <= 16); // R8
  end

  tgt_e          tgt;
  logic          bank_q, burst_q;
  logic [AW-1:0] ptr;
  logic [7:0]    reg_q, gen_q, ext_q;
  src_e          src_q;
  logic          rd_go, acc, step;

  assign rd_go = bus_rd && !bus_wr;
  assign acc   = rd_go || bus_wr;
  assign step  = acc && (tgt == TGT_DATA);

  xram_decode u_dec (
    .addr (bus_addr),
    .bank (bank_q),
    .tgt  (tgt)
  );

  xram_ptr #(.AW(AW)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .ld_lo (bus_wr && tgt == TGT_PLO),
    .ld_hi (bus_wr && tgt == TGT_PHI),
    .wbyte (bus_wdata),
    .step  (step),
    .burst (burst_q),
    .ptr   (ptr)
  );

  xram_mem #(.DEPTH(GEN_DEPTH), .AW(ADDR_W)) u_gen (
    .clk   (clk),
    .en    (acc && tgt == TGT_GEN),
    .we    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (gen_q)
  );

  xram_mem #(.DEPTH(EXT_DEPTH), .AW(AW)) u_ext (
    .clk   (clk),
    .en    (step),
    .we    (bus_wr),
    .addr  (ptr),
    .wdata (bus_wdata),
    .rdata (ext_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q  <= 1'b0;
      burst_q <= 1'b0;
    end else if (bus_wr) begin
      if (tgt == TGT_CTRL)  bank_q  <= bus_wdata[BANK_BIT];
      if (tgt == TGT_XCTRL) burst_q <= bus_wdata[BURST_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q <= '0;
      src_q <= SRC_REG;
    end else if (rd_go) begin
      case (tgt)
        TGT_GEN:  src_q <= SRC_GEN;
        TGT_DATA: src_q <= SRC_EXT;
        default:  src_q <= SRC_REG;
      endcase
      case (tgt)
        TGT_CTRL:  reg_q <= 8'(bank_q) << BANK_BIT;
        TGT_XCTRL: reg_q <= 8'(burst_q) << BURST_BIT;
        TGT_PLO:   reg_q <= ptr[7:0];
        TGT_PHI:   reg_q <= 8'(ptr >> 8);
        default:   reg_q <= '0;
      endcase
    end
  end

  always_comb begin
    case (src_q)
      SRC_GEN: bus_rdata = gen_q;
      SRC_EXT: bus_rdata = ext_q;
      default: bus_rdata = reg_q;
    endcase
  end

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bank_q && !burst_q && ptr == '0 && bus_rdata == 8'h00)); // R1
  AST_BANK0_PTR_SAFE: assert property (@(posedge clk) disable iff (rst)
    (!bank_q && bus_wr && bus_addr != OFS_CTRL) |=> $stable(ptr)); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R9
  AST_BANK_ONLY_ON_CTRL: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == OFS_CTRL) |=> $stable(bank_q)); // R2
endmodule

// File: tb/xram_port_tb_top.sv
module xram_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  xram_port #(.EXT_DEPTH(2048)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_b(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_b(input logic [6:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back('{exp: e, tag: tag});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    wr_b(7'h50, p[7:0]);
    wr_b(7'h51, p[15:8]);
  endtask

  // monitor: pops one expected item per read strobe seen at an edge
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        #1;
        if (exp_q.size() == 0) begin
          check(bus_rdata, 8'h00, "R9 unexpected read");
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(bus_rdata, it.exp, it.tag);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(bus_rdata, 8'h00, "R1 rdata after reset");
    rd_b(7'h0A, 8'h00, "R1 bank select clear");

    // R2: bank select
    wr_b(7'h0A, 8'h10);
    rd_b(7'h0A, 8'h10, "R2 bank bit readback");
    rd_b(7'h50, 8'h00, "R1 pointer low zero");
    rd_b(7'h51, 8'h00, "R1 pointer high zero");
    rd_b(7'h4A, 8'h00, "R1 burst off");

    // R3: bank 0 general bytes, incl. offsets that alias the page
    wr_b(7'h0A, 8'h00);
    wr_b(7'h0E, 8'h11);
    wr_b(7'h3F, 8'h22);
    wr_b(7'h40, 8'h33);
    wr_b(7'h7F, 8'h44);
    wr_b(7'h50, 8'h55);
    wr_b(7'h53, 8'h66);
    rd_b(7'h0E, 8'h11, "R3 gen 0x0E");
    rd_b(7'h3F, 8'h22, "R3 gen 0x3F");
    rd_b(7'h40, 8'h33, "R3 bank0 0x40");
    rd_b(7'h7F, 8'h44, "R3 bank0 0x7F");
    rd_b(7'h50, 8'h55, "R3 bank0 0x50");

    // bank 1: pointer untouched by bank-0 writes, general lower bytes visible
    wr_b(7'h0A, 8'h10);
    rd_b(7'h50, 8'h00, "R3 pointer untouched by bank0 write");
    rd_b(7'h0E, 8'h11, "R3 gen visible in bank1");
    rd_b(7'h40, 8'h00, "R10 unmapped page offset");
    wr_b(7'h40, 8'h99);
    wr_b(7'h52, 8'h77);
    rd_b(7'h52, 8'h00, "R10 unmapped page write ignored");

    // R4: pointer registers
    wr_b(7'h50, 8'h34);
    wr_b(7'h51, 8'hFF);
    rd_b(7'h50, 8'h34, "R4 pointer low");
    rd_b(7'h51, 8'h07, "R4 pointer high trimmed");

    // R5/R6: burst off
    set_ptr(16'h0123);
    wr_b(7'h53, 8'hA5);
    rd_b(7'h50, 8'h23, "R6 pointer holds after write");
    rd_b(7'h53, 8'hA5, "R5 data port read");
    rd_b(7'h50, 8'h23, "R6 pointer holds after read");
    set_ptr(16'h0124);
    wr_b(7'h53, 8'h5A);
    set_ptr(16'h0123);
    rd_b(7'h53, 8'hA5, "R5 neighbour unaffected");
    set_ptr(16'h0124);
    rd_b(7'h53, 8'h5A, "R5 second location");

    // R9: read data holds across idle and writes
    @(negedge clk);
    check(bus_rdata, 8'h5A, "R9 hold idle");
    wr_b(7'h0E, 8'hEE);
    repeat (2) @(negedge clk);
    check(bus_rdata, 8'h5A, "R9 hold across write");

    // R7: burst
    wr_b(7'h4A, 8'hFF);
    rd_b(7'h4A, 8'h20, "R7 burst bit readback");
    set_ptr(16'h0200);
    for (int i = 0; i < 8; i++) wr_b(7'h53, 8'(i * 7 + 3));
    rd_b(7'h50, 8'h08, "R7 pointer advanced by writes");
    rd_b(7'h51, 8'h02, "R7 pointer high after writes");
    set_ptr(16'h0200);
    for (int i = 0; i < 8; i++) rd_b(7'h53, 8'(i * 7 + 3), "R7 burst read old pointer");
    rd_b(7'h50, 8'h08, "R7 pointer advanced by reads");

    // R8: wrap
    set_ptr(16'h07FF);
    wr_b(7'h53, 8'hC3);
    rd_b(7'h50, 8'h00, "R8 wrap low");
    rd_b(7'h51, 8'h00, "R8 wrap high");
    wr_b(7'h53, 8'h3C);
    set_ptr(16'h07FF);
    rd_b(7'h53, 8'hC3, "R8 last location");
    rd_b(7'h53, 8'h3C, "R8 location zero after wrap");

    // R4: upper pointer bits ignored
    set_ptr(16'hF800);
    rd_b(7'h53, 8'h3C, "R4 high bits discarded");

    // R10 / R2: reserved offsets and control readback
    wr_b(7'h05, 8'hFF);
    rd_b(7'h05, 8'h00, "R10 reserved low offset");
    wr_b(7'h0A, 8'hFF);
    rd_b(7'h0A, 8'h10, "R2 only bank bit reads back");
    wr_b(7'h0A, 8'h00);
    rd_b(7'h40, 8'h33, "R3 bank0 0x40 kept");
    rd_b(7'h53, 8'h66, "R3 bank0 0x53 kept");
    rd_b(7'h0E, 8'hEE, "R3 gen rewritten");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) check(8'(exp_q.size()), 8'h00, "R9 pending reads");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule